// File: doc/BRIEF.md
# Power-Up Configuration Load Sequencer

This block runs the start-up of a configurable device. After a synchronous reset it keeps the device quiet for a power-on window whose length is given in clock cycles. The length comes from an input and is clamped to a parameter ceiling that corresponds to 10 ms. At the end of the window it samples a select input, once, to choose one of four stored configuration images. It then copies that image, word by word, from a non-volatile memory with a one-cycle read latency into the working register file.

Only when the last word has been written does the sequencer open the host write port. In the same cycle it emits a one-cycle request to start PLL locking. From then on, host writes overwrite working registers. Host writes that arrive earlier are dropped and flagged as busy. Any later reset throws away the host-written values and repeats the whole sequence, so the stored image comes back. The rest of the chip reads the working registers through a registered read port that block RAM can implement.

Top module: `cfg_boot_seq`

## Requirements
- R1: While `rst` is high, and on the first sample after it, `port_ready`, `lock_start`, `host_busy` and `nvm_rd_en` are all 0.
- R2: After `rst` falls, no memory read occurs for L cycles, where L = max(1, min(`por_len`, POR_MAX)). The first read is issued in the L-th cycle, that is, on the sample after the L-th rising edge with reset low.
- R3: A `por_len` above POR_MAX gives a window of exactly POR_MAX cycles. A `por_len` of 0 behaves as 1.
- R4: `img_sel` is sampled only at the end of the window. The read address is {image index, word index}, with the image index in the upper IMG_W bits. Changing `img_sel` during the load has no effect on the loaded data.
- R5: The load reads word indices 0 to 2^ADDR_W−1 in ascending order, one per cycle. Each word is written to the working register of the same index one cycle after its read. `port_ready` first reads 1 on sample L+N+1 after reset release, where N = 2^ADDR_W.
- R6: `lock_start` is high for exactly one cycle, which is the first cycle in which `port_ready` is high.
- R7: Once high, `port_ready` stays high until the next reset.
- R8: A host write presented while `port_ready` is 0 does not change any working register, and `host_busy` is 1 in the following cycle.
- R9: A host write presented while `port_ready` is 1, including the `lock_start` cycle, updates the addressed register, and `host_busy` stays 0.
- R10: After any reset, every working register again holds the selected stored image, regardless of earlier host writes.
- R11: `cfg_rd_data` shows the register addressed by `cfg_rd_addr` one clock after the address is presented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; restarts the whole sequence |
| por_len | input | POR_W | Power-on window length in cycles, held stable |
| img_sel | input | IMG_W | Stored image choice, sampled at the end of the window |
| nvm_rd_en | output | 1 | Read strobe to the stored-image memory |
| nvm_rd_addr | output | IMG_W+ADDR_W | {image, word} read address |
| nvm_rd_data | input | DATA_W | Read data, valid one cycle after the strobe |
| host_wr_en | input | 1 | Host register write request |
| host_wr_addr | input | ADDR_W | Host write register index |
| host_wr_data | input | DATA_W | Host write data |
| host_busy | output | 1 | A host write was dropped in the previous cycle |
| port_ready | output | 1 | Host port open; image fully loaded |
| lock_start | output | 1 | One-cycle request to begin PLL locking |
| cfg_rd_addr | input | ADDR_W | Working register read index |
| cfg_rd_data | output | DATA_W | Working register value, one cycle after the index |

## Verification
The bench times the distance from reset release to `port_ready` for window lengths of 0, in range and above the ceiling. An off-by-one in the window counter or the read pipeline, or a missing clamp, moves that edge by a cycle or more. It pokes a host write at an already loaded register late in the load. A design that opened the port early would keep that value instead of the image and would leave `host_busy` low. It also flips `img_sel` mid-load, and a design that kept sampling the select would fill the upper registers from the wrong image. Random host writes are followed by a reset and a full readback, so a register file that survived reset, or a partial reload, shows stale words.

// File: rtl/cfg_boot_pkg.sv
package cfg_boot_pkg;
  typedef enum logic [1:0] {
    ST_HOLD  = 2'd0,
    ST_LOAD  = 2'd1,
    ST_READY = 2'd2,
    ST_RUN   = 2'd3
  } boot_state_t;
endpackage

// File: rtl/cfg_por_timer.sv
module cfg_por_timer #(
  parameter int POR_W   = 22,
  parameter int POR_MAX = 2_500_000
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [POR_W-1:0] por_len,
  output logic             done
);
  localparam logic [POR_W-1:0] LIMIT = POR_W'(POR_MAX);

  logic [POR_W-1:0] cnt;
  logic [POR_W-1:0] eff_len;

  always_comb begin
    eff_len = (por_len > LIMIT) ? LIMIT : por_len;
    if (eff_len == '0) eff_len = POR_W'(1);
  end

  assign done = run && (({1'b0, cnt} + 1'b1) >= {1'b0, eff_len});

  always_ff @(posedge clk) begin
    if (rst || !run) cnt <= '0;
    else             cnt <= cnt + 1'b1;
  end

  AST_POR_BOUND: assert property (@(posedge clk) disable iff (rst)
    run |-> (cnt < eff_len)); // R2
endmodule

// File: rtl/cfg_img_loader.sv
module cfg_img_loader #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8,
  parameter int IMG_W  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    active,
  input  logic [IMG_W-1:0]        img,
  output logic                    nvm_rd_en,
  output logic [IMG_W+ADDR_W-1:0] nvm_rd_addr,
  input  logic [DATA_W-1:0]       nvm_rd_data,
  output logic                    wr_en,
  output logic [ADDR_W-1:0]       wr_addr,
  output logic [DATA_W-1:0]       wr_data,
  output logic                    done
);
  logic [ADDR_W:0]   rd_cnt;
  logic              vld_q;
  logic [ADDR_W-1:0] wa_q;

  assign nvm_rd_en   = active && !rd_cnt[ADDR_W];
  assign nvm_rd_addr = {img, rd_cnt[ADDR_W-1:0]};

  always_ff @(posedge clk) begin
    if (rst || !active) begin
      rd_cnt <= '0;
      vld_q  <= 1'b0;
      wa_q   <= '0;
    end else begin
      if (!rd_cnt[ADDR_W]) rd_cnt <= rd_cnt + 1'b1;
      vld_q <= nvm_rd_en;
      wa_q  <= rd_cnt[ADDR_W-1:0];
    end
  end

  assign wr_en   = vld_q;
  assign wr_addr = wa_q;
  assign wr_data = nvm_rd_data;
  assign done    = vld_q && (wa_q == {ADDR_W{1'b1}});

  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> $past(nvm_rd_en)); // R5
  AST_LAST_STOPS_RD: assert property (@(posedge clk) disable iff (rst)
    done |-> !nvm_rd_en); // R5
endmodule

// File: rtl/cfg_regfile.sv
module cfg_regfile #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/cfg_boot_seq.sv
module cfg_boot_seq #(
  parameter int ADDR_W  = 6,
  parameter int DATA_W  = 8,
  parameter int NUM_IMG = 4,
  parameter int POR_W   = 22,
  parameter int POR_MAX = 2_500_000,
  localparam int IMG_W  = (NUM_IMG > 1) ? $clog2(NUM_IMG) : 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [POR_W-1:0]        por_len,
  input  logic [IMG_W-1:0]        img_sel,
  output logic                    nvm_rd_en,
  output logic [IMG_W+ADDR_W-1:0] nvm_rd_addr,
  input  logic [DATA_W-1:0]       nvm_rd_data,
  input  logic                    host_wr_en,
  input  logic [ADDR_W-1:0]       host_wr_addr,
  input  logic [DATA_W-1:0]       host_wr_data,
  output logic                    host_busy,
  output logic                    port_ready,
  output logic                    lock_start,
  input  logic [ADDR_W-1:0]       cfg_rd_addr,
  output logic [DATA_W-1:0]       cfg_rd_data
);
  import cfg_boot_pkg::*;

  boot_state_t       state;
  logic [IMG_W-1:0]  img_q;
  logic              ready_q, lock_q, busy_q;
  logic              por_done, ld_done;
  logic              ld_wr_en;
  logic [ADDR_W-1:0] ld_wr_addr;
  logic [DATA_W-1:0] ld_wr_data;
  logic              host_ok;
  logic              rf_wr_en;
  logic [ADDR_W-1:0] rf_wr_addr;
  logic [DATA_W-1:0] rf_wr_data;

  cfg_por_timer #(.POR_W(POR_W), .POR_MAX(POR_MAX)) u_timer (
    .clk(clk), .rst(rst), .run(state == ST_HOLD),
    .por_len(por_len), .done(por_done)
  );

  cfg_img_loader #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .IMG_W(IMG_W)) u_loader (
    .clk(clk), .rst(rst), .active(state == ST_LOAD), .img(img_q),
    .nvm_rd_en(nvm_rd_en), .nvm_rd_addr(nvm_rd_addr), .nvm_rd_data(nvm_rd_data),
    .wr_en(ld_wr_en), .wr_addr(ld_wr_addr), .wr_data(ld_wr_data), .done(ld_done)
  );

  // Host path opens only once the image is complete
  assign host_ok    = host_wr_en && ready_q;
  assign rf_wr_en   = ld_wr_en || host_ok;
  assign rf_wr_addr = ld_wr_en ? ld_wr_addr : host_wr_addr;
  assign rf_wr_data = ld_wr_en ? ld_wr_data : host_wr_data;

  cfg_regfile #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rf (
    .clk(clk), .wr_en(rf_wr_en), .wr_addr(rf_wr_addr), .wr_data(rf_wr_data),
    .rd_addr(cfg_rd_addr), .rd_data(cfg_rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_HOLD;
      img_q   <= '0;
      ready_q <= 1'b0;
      lock_q  <= 1'b0;
      busy_q  <= 1'b0;
    end else begin
      busy_q <= host_wr_en && !ready_q;
      case (state)
        ST_HOLD: if (por_done) begin
          img_q <= img_sel;
          state <= ST_LOAD;
        end
        ST_LOAD: if (ld_done) begin
          state   <= ST_READY;
          ready_q <= 1'b1;
          lock_q  <= 1'b1;
        end
        ST_READY: begin
          lock_q <= 1'b0;
          state  <= ST_RUN;
        end
        default: state <= ST_RUN;
      endcase
    end
  end

  assign port_ready = ready_q;
  assign lock_start = lock_q;
  assign host_busy  = busy_q;

  AST_LOCK_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    lock_start |=> !lock_start); // R6
  AST_LOCK_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    lock_start |-> port_ready); // R6
  AST_READY_STICKY: assert property (@(posedge clk) disable iff (rst)
    port_ready |=> port_ready); // R7
  AST_NO_READ_WHEN_READY: assert property (@(posedge clk) disable iff (rst)
    port_ready |-> !nvm_rd_en); // R5
  AST_EARLY_WR_BUSY: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && !port_ready) |=> host_busy); // R8
  AST_LATE_WR_NOT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (host_wr_en && port_ready) |=> !host_busy); // R9
  AST_IMG_HELD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(img_q)); // R4
endmodule

// File: tb/cfg_boot_seq_bench.sv
`timescale 1ns/1ps
module cfg_boot_seq_bench;
  localparam int AW = 4, DW = 8, IW = 2, PW = 24, PMAX = 40;
  localparam int N = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [PW-1:0] por_len = '0;
  logic [IW-1:0] img_sel = '0;
  logic nvm_rd_en;
  logic [IW+AW-1:0] nvm_rd_addr;
  logic [DW-1:0] nvm_rd_data;
  logic host_wr_en = 1'b0;
  logic [AW-1:0] host_wr_addr = '0;
  logic [DW-1:0] host_wr_data = '0;
  logic host_busy, port_ready, lock_start;
  logic [AW-1:0] cfg_rd_addr = '0;
  logic [DW-1:0] cfg_rd_data;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] exp_rf [N];

  always #2 clk = ~clk;

  cfg_boot_seq #(.ADDR_W(AW), .DATA_W(DW), .NUM_IMG(4), .POR_W(PW), .POR_MAX(PMAX)) u_cfg_boot_seq (
    .clk(clk), .rst(rst), .por_len(por_len), .img_sel(img_sel),
    .nvm_rd_en(nvm_rd_en), .nvm_rd_addr(nvm_rd_addr), .nvm_rd_data(nvm_rd_data),
    .host_wr_en(host_wr_en), .host_wr_addr(host_wr_addr), .host_wr_data(host_wr_data),
    .host_busy(host_busy), .port_ready(port_ready), .lock_start(lock_start),
    .cfg_rd_addr(cfg_rd_addr), .cfg_rd_data(cfg_rd_data)
  );

  function automatic logic [DW-1:0] img_word(int img, int a);
    return DW'((img * 53 + a * 29 + 7) ^ (a << 2) ^ (img << 5));
  endfunction

  // stored-image memory model, one-cycle read latency
  always_ff @(posedge clk)
    if (nvm_rd_en) nvm_rd_data <= img_word(int'(nvm_rd_addr[IW+AW-1:AW]), int'(nvm_rd_addr[AW-1:0]));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (act !== expv) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  function automatic int win_len(int len);
    int l;
    l = (len > PMAX) ? PMAX : len;
    return (l == 0) ? 1 : l;
  endfunction

  // reset, then run the window and load; optional early poke, select swap, ready-cycle write
  task automatic boot(input int len, input int img, input bit poke, input bit swap, input bit ready_wr);
    int L, s;
    rst = 1'b1; por_len = PW'(len); img_sel = IW'(img);
    step(); step();
    chk("R1 ready in reset", port_ready, 0);
    chk("R1 lock in reset", lock_start, 0);
    chk("R1 busy in reset", host_busy, 0);
    chk("R1 read in reset", nvm_rd_en, 0);
    rst = 1'b0;
    L = win_len(len);
    s = 0;
    for (int i = 0; i < 200; i++) begin
      step(); s++;
      if (s == 1) chk("R1 ready after reset", port_ready, 0);
      if (L > 1 && s == L - 1) chk("R2 no read in window", nvm_rd_en, 0);
      if (s == L) begin
        chk("R2 first read at window end", nvm_rd_en, 1);
        chk("R4 first read address", nvm_rd_addr, {IW'(img), AW'(0)});
        if (swap) img_sel = ~IW'(img);
      end
      if (poke && s == L + N) begin
        chk("R8 busy after early write", host_busy, 1);
        host_wr_en = 1'b0;
      end
      if (port_ready) break;
      if (poke && s == L + N - 1) begin
        host_wr_en = 1'b1; host_wr_addr = '0; host_wr_data = ~img_word(img, 0);
      end
    end
    chk("R5 cycles to ready", s, L + N + 1);
    chk("R6 lock with first ready", lock_start, 1);
    for (int a = 0; a < N; a++) exp_rf[a] = img_word(img, a);
    if (ready_wr) begin
      host_wr_en = 1'b1; host_wr_addr = AW'(2); host_wr_data = 8'hA5;
      exp_rf[2] = 8'hA5;
    end
    step();
    host_wr_en = 1'b0;
    chk("R6 lock drops", lock_start, 0);
    chk("R7 ready stays", port_ready, 1);
    if (ready_wr) chk("R9 no busy on ready-cycle write", host_busy, 0);
    img_sel = IW'(img);
  endtask

  task automatic host_wr(input int a, input logic [DW-1:0] d);
    host_wr_en = 1'b1; host_wr_addr = AW'(a); host_wr_data = d;
    step();
    host_wr_en = 1'b0;
    exp_rf[a] = d;
    chk("R9 no busy on open-port write", host_busy, 0);
  endtask

  task automatic read_all(input string req);
    for (int a = 0; a < N; a++) begin
      cfg_rd_addr = AW'(a);
      step();
      chk(req, cfg_rd_data, exp_rf[a]);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    boot(5, 1, 1'b0, 1'b0, 1'b0);
    read_all("R5 R11 image 1 loaded");
    boot(7, 0, 1'b0, 1'b0, 1'b1);
    host_wr(9, 8'h3C);
    host_wr(15, 8'hC3);
    read_all("R9 host writes applied");
    boot(0, 2, 1'b1, 1'b1, 1'b0);
    read_all("R10 R8 R4 reload image 2, early write dropped");
    boot(100, 3, 1'b0, 1'b0, 1'b0);
    read_all("R3 clamped window image 3");
    for (int it = 0; it < 6; it++) begin
      for (int w = 0; w < 8; w++) host_wr(int'($urandom_range(0, N - 1)), DW'($urandom));
      read_all("R9 random writes");
      boot(int'($urandom_range(0, 50)), int'($urandom_range(0, 3)),
           1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      read_all("R10 random reload");
    end
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule